// File: doc/BRIEF.md
# Interrupt Pending Identification Aggregator

This block collects interrupt state for a small microcontroller core. Six peripheral register modules each own a bank of interrupt sources. A system group holds sources such as the watchdog. Each source has a latched flag and an enable bit. Peripherals raise flags with single-cycle set pulses. Software reads and writes the flag and enable banks over a simple register bus. Software clears a flag by writing a 1 to its bit.

The block reduces this state to one read-only 8-bit identification byte, with one summary bit per module and one bit for the system group. Software polls that byte to find which module needs service. A single request line to the core is the OR of the identification bits, gated by a global enable bit.

Top module: `irq_pend_id`

## Requirements
- R1: After reset, every flag, every enable, the global enable, the identification byte (address 14) and `irq_o` are all 0.
- R2: The identification byte at address 14 is read-only. A write to address 14 changes no flag, no enable, no global enable and no read value.
- R3: Identification bit m (m = 0..5) is 1 exactly when module m has at least one source whose flag and enable are both 1. A flagged source that is not enabled leaves the bit at 0.
- R4: Identification bit 7 is 1 exactly when at least one system source has both its flag (address 12) and its enable (address 13) set.
- R5: Identification bit 6 always reads 0, even when every other bit is 1.
- R6: A set pulse on a source raises its flag on the next clock edge. The flag then stays at 1 after the pulse ends, until software clears it.
- R7: Writing to a flag register (module m at address 2m, system at 12) clears exactly the flags whose write-data bit is 1. Flags under a 0 bit keep their value.
- R8: When a set pulse and a software clear hit the same flag in the same cycle, the flag ends up at 1.
- R9: Clearing a source's enable drops its module's summary bit on the next edge, while the flag itself stays readable as 1.
- R10: `irq_o` equals the global enable (address 15, bit 0) ANDed with the OR of all identification bits.
- R11: Enable registers (module m at address 2m+1, system at 13) take the written value directly and read it back in bits [NSRC-1:0] (or [NSYS-1:0]), with upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| set_i | input | 6*NSRC | Per-source set pulses; module m uses bits [m*NSRC +: NSRC] |
| sys_set_i | input | NSYS | Set pulses for the system sources |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with its defaults: NSRC = 4 sources per module and NSYS = 2 system sources. With these values every flag and enable bit of all six modules can be reached through a handful of bus writes. The all-ones case puts every identification bit except the reserved one at 1 at the same time. A single source index per module is enough to show that the bit mapping to each module is exact. The collision of a set pulse and a write-one clear is driven in one cycle, so the precedence rule is observed directly.

// File: rtl/irq_pend_id.sv
module irq_pend_id #(
  parameter int NSRC = 4,
  parameter int NSYS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6*NSRC-1:0] set_i,
  input  logic [NSYS-1:0]   sys_set_i,
  input  logic [3:0]        bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_o
);
  localparam int NMOD = 6;
  localparam logic [3:0] A_SFLG  = 4'd12;
  localparam logic [3:0] A_SEN   = 4'd13;
  localparam logic [3:0] A_IDENT = 4'd14;
  localparam logic [3:0] A_CTRL  = 4'd15;

  logic [NMOD*NSRC-1:0] flg_q, en_q;
  logic [NSYS-1:0]      sflg_q, sen_q;
  logic                 gie_q;
  logic [NMOD-1:0]      mod_pend;
  logic [7:0]           ident;

  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    localparam logic [3:0] A_F = 4'(2*m);
    localparam logic [3:0] A_E = 4'(2*m+1);
    logic [NSRC-1:0] clr;
    assign clr = (bus_we && bus_addr == A_F) ? bus_wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        flg_q[m*NSRC +: NSRC] <= '0;
        en_q[m*NSRC +: NSRC]  <= '0;
      end else begin
        flg_q[m*NSRC +: NSRC] <= (flg_q[m*NSRC +: NSRC] & ~clr) | set_i[m*NSRC +: NSRC];
        if (bus_we && bus_addr == A_E)
          en_q[m*NSRC +: NSRC] <= bus_wdata[NSRC-1:0];
      end

    assign mod_pend[m] = |(flg_q[m*NSRC +: NSRC] & en_q[m*NSRC +: NSRC]);
  end

  logic [NSYS-1:0] sclr;
  assign sclr = (bus_we && bus_addr == A_SFLG) ? bus_wdata[NSYS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sflg_q <= '0;
      sen_q  <= '0;
      gie_q  <= 1'b0;
    end else begin
      sflg_q <= (sflg_q & ~sclr) | sys_set_i;
      if (bus_we && bus_addr == A_SEN)  sen_q <= bus_wdata[NSYS-1:0];
      if (bus_we && bus_addr == A_CTRL) gie_q <= bus_wdata[0];
    end

  assign ident = {|(sflg_q & sen_q), 1'b0, mod_pend};
  assign irq_o = gie_q & |ident;

  always_comb begin
    bus_rdata = '0;
    for (int m = 0; m < NMOD; m++) begin
      if (bus_addr == 4'(2*m))   bus_rdata[NSRC-1:0] = flg_q[m*NSRC +: NSRC];
      if (bus_addr == 4'(2*m+1)) bus_rdata[NSRC-1:0] = en_q[m*NSRC +: NSRC];
    end
    case (bus_addr)
      A_SFLG:  bus_rdata[NSYS-1:0] = sflg_q;
      A_SEN:   bus_rdata[NSYS-1:0] = sen_q;
      A_IDENT: bus_rdata = ident;
      A_CTRL:  bus_rdata[0] = gie_q;
      default: ;
    endcase
  end
endmodule

module irq_pend_id_chk #(
  parameter int NSRC = 4,
  parameter int NSYS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6*NSRC-1:0] set_i,
  input logic [3:0]        bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic              irq_o,
  input logic [6*NSRC-1:0] flg_q,
  input logic [6*NSRC-1:0] en_q,
  input logic [NSYS-1:0]   sflg_q,
  input logic [NSYS-1:0]   sen_q,
  input logic              gie_q
);
  for (genvar k = 0; k < 6*NSRC; k++) begin : g_bit
    localparam logic [3:0] A_F = 4'(2*(k/NSRC));
    localparam int B = k % NSRC;

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flg_q[k]);

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_F && bus_wdata[B] && !set_i[k]) |=> !flg_q[k]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[k] && !(bus_we && bus_addr == A_F && bus_wdata[B])) |=> flg_q[k]);
  end

  p_ident_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd14) |=> ($stable(en_q) && $stable(sen_q) && $stable(gie_q)));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (gie_q && ((|(flg_q & en_q)) || (|(sflg_q & sen_q)))));
endmodule

bind irq_pend_id irq_pend_id_chk #(.NSRC(NSRC), .NSYS(NSYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_i(set_i), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .flg_q(flg_q), .en_q(en_q),
  .sflg_q(sflg_q), .sen_q(sen_q), .gie_q(gie_q));

// File: tb/irq_pend_id_test.sv
module irq_pend_id_test;
  localparam int NSRC = 4;
  localparam int NSYS = 2;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [6*NSRC-1:0] set_i = '0;
  logic [NSYS-1:0]   sys_set_i = '0;
  logic [3:0]        bus_addr = '0;
  logic              bus_we = 0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_pend_id #(.NSRC(NSRC), .NSYS(NSYS)) uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] a, logic we, logic [7:0] d,
                     logic [6*NSRC-1:0] s, logic [NSYS-1:0] ss);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; set_i = s; sys_set_i = ss;
    @(negedge clk);
    bus_we = 0; set_i = '0; sys_set_i = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cyc(a, 1'b1, d, '0, '0);
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 0;
    #1 d = bus_rdata;
  endtask

  task automatic clear_all();
    for (int a = 0; a < 14; a++) wr(4'(a), 8'hFF);
    for (int m = 0; m < 7; m++) wr(4'(2*m+1), 8'h00);
    wr(4'd15, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reset read", d, 8'h00);
    end
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_modules();
    logic [7:0] d;
    for (int m = 0; m < 6; m++) begin
      int s = m % NSRC;
      cyc(4'd0, 0, 0, (6*NSRC)'(1) << (m*NSRC + s), '0);
      rd(4'(2*m), d);
      chk("R6 flag latched", d, 8'(1 << s));
      rd(4'd14, d);
      chk("R3 flag without enable", d, 8'h00);
      wr(4'(2*m+1), 8'(1 << s));
      rd(4'(2*m+1), d);
      chk("R11 enable readback", d, 8'(1 << s));
      rd(4'd14, d);
      chk("R3 module bit", d, 8'(1 << m));
      wr(4'(2*m), 8'(1 << s));
      rd(4'd14, d);
      chk("R3 after clear", d, 8'h00);
      wr(4'(2*m+1), 8'h00);
    end
  endtask

  task automatic t_system();
    logic [7:0] d;
    cyc(4'd0, 0, 0, '0, 2'b10);
    wr(4'd13, 8'h01);
    rd(4'd14, d);
    chk("R4 wrong source enabled", d, 8'h00);
    wr(4'd13, 8'hFF);
    rd(4'd13, d);
    chk("R11 system enable upper bits", d, 8'h03);
    rd(4'd14, d);
    chk("R4 system bit", d, 8'h80);
    clear_all();
  endtask

  task automatic t_all_ones();
    logic [7:0] d;
    for (int m = 0; m < 7; m++) wr(4'(2*m+1), 8'hFF);
    cyc(4'd0, 0, 0, '1, '1);
    rd(4'd14, d);
    chk("R5 reserved bit with all pending", d, 8'hBF);
    wr(4'd14, 8'h00);
    rd(4'd14, d);
    chk("R2 ident after write", d, 8'hBF);
    rd(4'd5, d);
    chk("R2 enable after ident write", d, 8'h0F);
    rd(4'd15, d);
    chk("R2 gie after ident write", d, 8'h00);
    clear_all();
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    cyc(4'd0, 0, 0, 24'hF << (2*NSRC), '0);
    wr(4'd4, 8'h05);
    rd(4'd4, d);
    chk("R7 partial clear", d, 8'h0A);
    cyc(4'd4, 1, 8'h0F, 24'h8 << (2*NSRC), '0);
    rd(4'd4, d);
    chk("R8 set beats clear", d, 8'h08);
    clear_all();
  endtask

  task automatic t_disable();
    logic [7:0] d;
    cyc(4'd0, 0, 0, 24'h2 << (3*NSRC), '0);
    wr(4'd7, 8'h02);
    rd(4'd14, d);
    chk("R9 pending", d, 8'h08);
    wr(4'd7, 8'h00);
    rd(4'd14, d);
    chk("R9 disabled bit", d, 8'h00);
    rd(4'd6, d);
    chk("R9 flag kept", d, 8'h02);
    clear_all();
  endtask

  task automatic t_irq();
    logic [7:0] d;
    cyc(4'd0, 0, 0, 24'h1, '0);
    wr(4'd1, 8'h01);
    #1 chk("R10 irq gated off", {7'b0, irq_o}, 8'h00);
    wr(4'd15, 8'h01);
    #1 chk("R10 irq on", {7'b0, irq_o}, 8'h01);
    rd(4'd15, d);
    chk("R10 gie readback", d, 8'h01);
    wr(4'd0, 8'h01);
    #1 chk("R10 irq after clear", {7'b0, irq_o}, 8'h00);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_modules();
    t_system();
    t_all_ones();
    t_w1c();
    t_disable();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule